// File: doc/BRIEF.md
# Two-Channel Output Mute Controller

This block sits beside the datapath of a stereo output converter and decides, sample by sample, whether each channel should be silenced. Samples arrive as one channel A word and one channel B word, qualified by a frame strobe. A per-channel silence detector counts how many strobed samples in a row hold a static value, either all zeros or all ones. When that count reaches a threshold, the channel is muted automatically. The first non-static sample lifts the mute.

An 8-bit control register adds three things: manual mute bits for each channel, an enable for the automatic detector, and a link option. With the link option set, each mute indicator shows the AND of both channels' mute conditions. For each channel the block drives two outputs. A mute-enable goes to the datapath. An active-high indicator reports that the mute is in force. For a manual mute, the indicator waits until the volume ramp reports completion on a ramp-done input.

Top module: `dac_mute_ctrl`

## Requirements
- R1: A channel whose last `SILENCE_LEN` (default 8192) strobed samples were all static is muted: its mute-enable and its indicator are high from the clock edge that accepts the `SILENCE_LEN`-th such sample. "Static" means every bit of the sample is 0, or every bit is 1.
- R2: A strobed sample that is not static releases that channel's automatic mute at the edge that accepts it, and restarts the count from zero.
- R3: Channels A and B are detected and muted separately. Silence on one channel has no effect on the other channel's outputs.
- R4: Register bit 7 (auto enable) resets to 1. While it is 0, no automatic mute is raised, and a channel that was auto-muted is released at once. The silence counters keep running, so setting the bit again during silence that is still going on mutes the channel again straight away.
- R5: Register bit 5 (link) resets to 0, which keeps the indicators independent. While it is 1, both indicators equal the AND of the two channels' internal mute conditions.
- R6: Register bit 4 (manual mute A) and bit 3 (manual mute B) reset to 0. Setting one of them raises that channel's mute-enable from the write edge onward. Clearing it drops the mute-enable and the indicator at once, unless an automatic mute is also active.
- R7: For a manual mute, the indicator stays low until the channel's ramp-done input is sampled high at a clock edge after the one that stored the manual bit. It then stays high until the manual bit is cleared, even if ramp-done later falls.
- R8: While a channel is auto-muted and link is 0, its indicator is high.
- R9: Register bits 6, 2, 1 and 0 always read back as 0 and ignore writes. The register reads 0x80 after reset.
- R10: A sample is counted only on a clock edge where the frame strobe is high. Cycles with the strobe low neither add to the count nor release a mute.
- R11: The silence count saturates at `SILENCE_LEN`. Silence of any length therefore keeps the channel muted without wrapping around.
- R12: During and after reset, all four mute outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| frame_vld | input | 1 | Frame strobe; the samples are taken on edges where this is high |
| samp_a | input | SW | Channel A sample, two's complement |
| samp_b | input | SW | Channel B sample, two's complement |
| reg_we | input | 1 | Control register write enable |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register readback |
| ramp_done_a | input | 1 | Channel A volume ramp finished |
| ramp_done_b | input | 1 | Channel B volume ramp finished |
| mute_en_a | output | 1 | Mute request to the channel A datapath |
| mute_en_b | output | 1 | Mute request to the channel B datapath |
| mute_ind_a | output | 1 | Channel A mute indicator, active high |
| mute_ind_b | output | 1 | Channel B mute indicator, active high |

## Verification
The bench places the threshold exactly. After one sample fewer than the threshold the channel must still be playing, and one more sample must mute it; a counter off by one in either direction fails one of these two checks. A detector that misses the all-ones case, counts cycles where the strobe is low, or wraps after long silence would drop the mute where the bench expects it to hold. The bench also releases a mute with a single active sample and then checks that a fresh full run is needed, which catches a counter that is not cleared on release. On the manual path it checks the following: the indicator stays low until the ramp completes, it stays up after ramp-done falls, a ramp-done that is already high is not taken in the write cycle, and it drops at the same moment the manual bit is cleared. The link option, readback of the reserved bits and re-enabling auto-mute during silence that is still going on are each checked at the outputs.

// File: rtl/dac_mute_pkg.sv
package dac_mute_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_AUTO  = 7;
  localparam int BIT_LINK  = 5;
  localparam int BIT_MAN_A = 4;
  localparam int BIT_MAN_B = 3;
  localparam int NCH       = 2;

  localparam logic [REG_W-1:0] REG_RST  = 8'h80;
  localparam logic [REG_W-1:0] REG_MASK = 8'hB8;

  typedef struct packed {
    logic           auto_en;
    logic           link;
    logic [NCH-1:0] man;      // index 0 = channel A, 1 = channel B
  } mute_cfg_t;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/mute_reg.sv
module mute_reg
  import dac_mute_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output mute_cfg_t        cfg
);
  logic [REG_W-1:0] reg_q;
  logic [REG_W-1:0] reg_d;

  always_comb begin
    reg_d = reg_q;
    if (we) reg_d = wdata & REG_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= REG_RST;
    else        reg_q <= reg_d;
  end

  assign rdata       = reg_q;
  assign cfg.auto_en = reg_q[BIT_AUTO];
  assign cfg.link    = reg_q[BIT_LINK];
  assign cfg.man[0]  = reg_q[BIT_MAN_A];
  assign cfg.man[1]  = reg_q[BIT_MAN_B];
endmodule

// File: rtl/silence_ctr.sv
module silence_ctr #(
  parameter int SW          = 24,
  parameter int SILENCE_LEN = 8192
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic [SW-1:0] samp,
  input  logic          auto_en,
  output logic          hit
);
  localparam int CW = $clog2(SILENCE_LEN + 1);
  localparam logic [CW-1:0] CMAX = CW'(SILENCE_LEN);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          is_static;
  logic          cnt_en;

  assign is_static = (samp == '0) || (samp == '1);
  assign cnt_en    = vld;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) begin
      if (!is_static)        cnt_d = '0;
      else if (cnt_q != CMAX) cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit = auto_en && (cnt_q == CMAX);
endmodule

// File: rtl/mute_indicator.sv
module mute_indicator (
  input  logic clk,
  input  logic rst_n,
  input  logic man,
  input  logic ramp_done,
  input  logic auto_hit,
  output logic mute_en,
  output logic cond
);
  logic done_q;
  logic done_d;

  always_comb begin
    done_d = man & (done_q | ramp_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign mute_en = auto_hit | man;
  assign cond    = auto_hit | (man & done_q);
endmodule

// File: rtl/dac_mute_ctrl.sv
module dac_mute_ctrl
  import dac_mute_pkg::*;
#(
  parameter int SW          = 24,
  parameter int SILENCE_LEN = 8192
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_vld,
  input  logic [SW-1:0] samp_a,
  input  logic [SW-1:0] samp_b,
  input  logic          reg_we,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          ramp_done_a,
  input  logic          ramp_done_b,
  output logic          mute_en_a,
  output logic          mute_en_b,
  output logic          mute_ind_a,
  output logic          mute_ind_b
);
  logic            rst_ns;
  mute_cfg_t       cfg;
  logic [SW-1:0]   samp_v [NCH];
  logic [NCH-1:0]  ramp_v;
  logic [NCH-1:0]  auto_hit;
  logic [NCH-1:0]  men;
  logic [NCH-1:0]  cond;
  logic [NCH-1:0]  ind;

  assign samp_v[0] = samp_a;
  assign samp_v[1] = samp_b;
  assign ramp_v    = {ramp_done_b, ramp_done_a};

  rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  mute_reg u_reg (
    .clk   (clk),
    .rst_n (rst_ns),
    .we    (reg_we),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cfg   (cfg)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    silence_ctr #(.SW(SW), .SILENCE_LEN(SILENCE_LEN)) u_sil (
      .clk     (clk),
      .rst_n   (rst_ns),
      .vld     (frame_vld),
      .samp    (samp_v[ch]),
      .auto_en (cfg.auto_en),
      .hit     (auto_hit[ch])
    );

    mute_indicator u_ind (
      .clk       (clk),
      .rst_n     (rst_ns),
      .man       (cfg.man[ch]),
      .ramp_done (ramp_v[ch]),
      .auto_hit  (auto_hit[ch]),
      .mute_en   (men[ch]),
      .cond      (cond[ch])
    );

    assign ind[ch] = cfg.link ? (&cond) : cond[ch];
  end

  assign mute_en_a  = men[0];
  assign mute_en_b  = men[1];
  assign mute_ind_a = ind[0];
  assign mute_ind_b = ind[1];
endmodule

// File: rtl/dac_mute_chk.sv
module dac_mute_chk #(
  parameter int SW = 24
) (
  input logic          clk,
  input logic          rst_ns,
  input logic          frame_vld,
  input logic [SW-1:0] samp_a,
  input logic [SW-1:0] samp_b,
  input logic          reg_we,
  input logic [7:0]    reg_rdata,
  input logic [1:0]    auto_hit,
  input logic          mute_en_a,
  input logic          mute_en_b,
  input logic          mute_ind_a,
  input logic          mute_ind_b
);
  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_rdata & 8'h47) == 8'h00);

  // R6
  man_a_mutes_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    reg_rdata[4] |-> mute_en_a);

  // R6
  man_b_mutes_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    reg_rdata[3] |-> mute_en_b);

  // R4
  auto_off_a_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!reg_rdata[7] && !reg_rdata[4]) |-> !mute_en_a);

  // R4
  auto_off_b_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!reg_rdata[7] && !reg_rdata[3]) |-> !mute_en_b);

  // R2
  release_a_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (frame_vld && !reg_we && !reg_rdata[4] && samp_a != '0 && samp_a != '1) |=> !mute_en_a);

  // R2
  release_b_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (frame_vld && !reg_we && !reg_rdata[3] && samp_b != '0 && samp_b != '1) |=> !mute_en_b);

  // R5
  link_equal_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    reg_rdata[5] |-> (mute_ind_a == mute_ind_b));

  // R8
  auto_ind_a_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (auto_hit[0] && !reg_rdata[5]) |-> mute_ind_a);

  // R8
  auto_ind_b_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (auto_hit[1] && !reg_rdata[5]) |-> mute_ind_b);

  // R7
  ramp_wait_a_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ($rose(reg_rdata[4]) && !auto_hit[0] && !reg_rdata[5]) |-> !mute_ind_a);

  // R7
  ramp_wait_b_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ($rose(reg_rdata[3]) && !auto_hit[1] && !reg_rdata[5]) |-> !mute_ind_b);
endmodule

bind dac_mute_ctrl dac_mute_chk #(.SW(SW)) u_chk (
  .clk        (clk),
  .rst_ns     (rst_ns),
  .frame_vld  (frame_vld),
  .samp_a     (samp_a),
  .samp_b     (samp_b),
  .reg_we     (reg_we),
  .reg_rdata  (reg_rdata),
  .auto_hit   (auto_hit),
  .mute_en_a  (mute_en_a),
  .mute_en_b  (mute_en_b),
  .mute_ind_a (mute_ind_a),
  .mute_ind_b (mute_ind_b)
);

// File: tb/dac_mute_ctrl_test.sv
`timescale 1ns/1ps
module dac_mute_ctrl_test;
  localparam int SW  = 24;
  localparam int LEN = 8192;
  localparam logic [SW-1:0] ACT_A = 24'h000123;
  localparam logic [SW-1:0] ACT_B = 24'h7FFFFF;
  localparam logic [SW-1:0] ZERO  = '0;
  localparam logic [SW-1:0] ONES  = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_vld = 1'b0;
  logic [SW-1:0] samp_a = '0;
  logic [SW-1:0] samp_b = '0;
  logic          reg_we = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          ramp_done_a = 1'b0;
  logic          ramp_done_b = 1'b0;
  logic          mute_en_a, mute_en_b, mute_ind_a, mute_ind_b;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dac_mute_ctrl #(.SW(SW), .SILENCE_LEN(LEN)) uut (
    .clk, .rst_n, .frame_vld, .samp_a, .samp_b, .reg_we, .reg_wdata,
    .reg_rdata, .ramp_done_a, .ramp_done_b,
    .mute_en_a, .mute_en_b, .mute_ind_a, .mute_ind_b
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic ea, input logic eb,
                         input logic ia, input logic ib);
    chk(req, "mute_en_a",  {7'd0, mute_en_a},  {7'd0, ea});
    chk(req, "mute_en_b",  {7'd0, mute_en_b},  {7'd0, eb});
    chk(req, "mute_ind_a", {7'd0, mute_ind_a}, {7'd0, ia});
    chk(req, "mute_ind_b", {7'd0, mute_ind_b}, {7'd0, ib});
  endtask

  task automatic feed(input int n, input logic [SW-1:0] a, input logic [SW-1:0] b);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_vld = 1'b1; samp_a = a; samp_b = b;
    end
    @(negedge clk);
    frame_vld = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic t_reset;
    // R12 R9
    chk("R12", "ind_a in reset", {7'd0, mute_ind_a}, 8'd0);
    chk("R12", "en_a in reset", {7'd0, mute_en_a}, 8'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9", "reset readback", reg_rdata, 8'h80);
    chk_out("R12", 0, 0, 0, 0);
  endtask

  task automatic t_auto_a;
    // R1 R3 R8: threshold exact, B stays live
    feed(LEN - 1, ZERO, ACT_B);
    chk_out("R1", 0, 0, 0, 0);
    feed(1, ZERO, ACT_B);
    chk_out("R1", 1, 0, 1, 0);
    chk("R3", "b untouched", {7'd0, mute_en_b}, 8'd0);
  endtask

  task automatic t_release;
    // R2: one active sample releases and restarts
    feed(1, ACT_A, ACT_B);
    chk_out("R2", 0, 0, 0, 0);
    feed(LEN - 1, ONES, ACT_B);
    chk_out("R2", 0, 0, 0, 0);
    feed(1, ONES, ACT_B);
    chk_out("R1", 1, 0, 1, 0);
    // R10: active samples with strobe low are ignored
    samp_a = ACT_A;
    repeat (5) @(negedge clk);
    chk_out("R10", 1, 0, 1, 0);
    // R11: long silence stays muted
    feed(LEN + 808, ZERO, ACT_B);
    chk_out("R11", 1, 0, 1, 0);
  endtask

  task automatic t_autodis;
    // R4
    wr(8'h00);
    chk_out("R4", 0, 0, 0, 0);
    feed(3, ZERO, ACT_B);
    chk_out("R4", 0, 0, 0, 0);
    wr(8'h80);
    chk_out("R4", 1, 0, 1, 0);
    feed(1, ACT_A, ACT_B);
    chk_out("R2", 0, 0, 0, 0);
  endtask

  task automatic t_manual;
    // R6 R7 channel A
    wr(8'h90);
    chk("R6", "readback", reg_rdata, 8'h90);
    chk_out("R7", 1, 0, 0, 0);
    @(negedge clk); ramp_done_a = 1'b1;
    @(negedge clk); ramp_done_a = 1'b0;
    chk_out("R7", 1, 0, 1, 0);
    @(negedge clk);
    chk_out("R7", 1, 0, 1, 0);
    wr(8'h80);
    chk_out("R6", 0, 0, 0, 0);
    // R7 channel B: ramp_done already high is not taken in the write edge
    ramp_done_b = 1'b1;
    wr(8'h88);
    chk_out("R7", 0, 1, 0, 0);
    @(negedge clk);
    chk_out("R7", 0, 1, 0, 1);
    ramp_done_b = 1'b0;
    wr(8'h80);
    chk_out("R6", 0, 0, 0, 0);
  endtask

  task automatic t_link;
    // R5
    feed(LEN, ZERO, ACT_B);
    chk_out("R5", 1, 0, 1, 0);
    wr(8'hA0);
    chk_out("R5", 1, 0, 0, 0);
    feed(LEN, ZERO, ZERO);
    chk_out("R5", 1, 1, 1, 1);
    wr(8'h80);
    feed(1, ACT_A, ZERO);
    chk_out("R3", 0, 1, 0, 1);
    feed(1, ACT_A, ACT_B);
    chk_out("R2", 0, 0, 0, 0);
  endtask

  task automatic t_reserved;
    // R9
    wr(8'hFF);
    chk("R9", "write ff", reg_rdata, 8'hB8);
    wr(8'h47);
    chk("R9", "write 47", reg_rdata, 8'h00);
    chk_out("R9", 0, 0, 0, 0);
    wr(8'h80);
    chk("R9", "restore", reg_rdata, 8'h80);
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_auto_a;
        t_release;
        t_autodis;
        t_manual;
        t_link;
        t_reserved;
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule